// File: doc/BRIEF.md
# PTP Announce Frame Snooper

This block sits beside an Ethernet frame stream that is presented as 16-bit words and classifies each frame as it goes by. It decides whether the frame holds a PTP Announce message. While the words pass, it captures the sequence ID, the ten-byte source port identity and the clock class. No copy of the frame is kept. Only a word index, a few classification flags and the captured fields are held as state.

Two carriers are accepted: PTP placed directly after the EtherType, and PTP inside IPv4/UDP. Either carrier may have one VLAN tag in front of it. The classifier follows the EtherType chain, and so knows where the PTP header starts by the time the header arrives. A one-cycle done strobe follows the last word of every frame. The announce flag and the captured fields are meaningful in that cycle.

Top module: `ann_snoop`

## Requirements
- R1: After synchronous reset, out_done and out_announce are 0 and every field output is 0.
- R2: When word 6 equals 0x88F7, the PTP header starts at word 7. The frame is an Announce when bits [11:8] of that word equal 0xB. The source port identity is taken from PTP words 10 to 14, first word most significant. The sequence ID is PTP word 15. The clock class is bits [15:8] of PTP word 24.
- R3: When word 6 equals 0x8100, word 8 is the EtherType. Every later field then sits two words further on than in the untagged case.
- R4: When the EtherType equals 0x0800, the IPv4 header starts at the next word (b). The frame is accepted only if all three hold: bits [15:8] of word b equal 0x45, bits [7:0] of word b+4 equal 17, and word b+11 equals 320. The PTP header then starts at word b+14.
- R5: An IPv4 frame fails classification, and out_announce stays low, if any of these holds: the version/length byte is not 0x45, the protocol is not 17, or the destination port is not 320.
- R6: out_done is high for exactly one cycle, in the cycle after the word that carries in_eof. out_announce is never high outside that cycle.
- R7: out_announce is low in three cases: the message type nibble is not 0xB, the EtherType is not 0x8100, 0x88F7 or 0x0800, or a second VLAN tag follows the first. Bits [15:12] of the first PTP word have no effect.
- R8: A frame that ends before its clock-class word still produces out_done, with out_announce low. This includes a frame of a single word. A frame whose last word is the clock-class word is detected.
- R9: A word with in_sof restarts classification, so back-to-back frames are judged independently. A frame cut short by a new in_sof leaves no trace in the next result.
- R10: Cycles with in_valid low are ignored. Idle gaps between words do not change the result, and the field outputs hold their values through them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A word is present on in_data |
| in_sof | input | 1 | Present word is the first of a frame |
| in_eof | input | 1 | Present word is the last of a frame |
| in_data | input | 16 | Frame word, earlier byte in bits [15:8] |
| out_done | output | 1 | One-cycle strobe after the last word |
| out_announce | output | 1 | Frame was an Announce (valid with out_done) |
| out_seq_id | output | 16 | Captured sequence ID |
| out_src_port | output | 80 | Captured source port identity |
| out_clock_class | output | 8 | Captured clock class |

## Verification
The hardest case to reach is a frame whose carrier checks pass but whose PTP layer is cut off or displaced. Examples are the combined VLAN-plus-IPv4 offset, a frame ending exactly on or one word before the clock-class word, and a new start-of-frame arriving halfway through a frame. The bench builds each frame word by word from the offsets in the requirements. It then truncates or alters single words, so that each rejection path and each boundary is reached with all other checks passing. It also sends frames back to back, with no idle cycle between them, and with idle gaps inside a frame.

// File: rtl/ann_snoop_pkg.sv
package ann_snoop_pkg;

    localparam int WORD_W       = 16;
    localparam int SPID_W       = 80;
    localparam int SPID_WORDS   = SPID_W / WORD_W;
    localparam int SEQ_W        = 16;
    localparam int CLASS_W      = 8;

    localparam logic [WORD_W-1:0] TYPE_VLAN = 16'h8100;
    localparam logic [WORD_W-1:0] TYPE_PTP  = 16'h88F7;
    localparam logic [WORD_W-1:0] TYPE_IPV4 = 16'h0800;
    localparam logic [7:0]        IP_VIHL   = 8'h45;
    localparam logic [7:0]        IP_UDP    = 8'd17;
    localparam logic [WORD_W-1:0] UDP_PORT  = 16'd320;
    localparam logic [3:0]        MSG_ANN   = 4'hB;

    localparam int ETYPE_IDX    = 6;
    localparam int VLAN_SHIFT   = 2;
    localparam int IP_VIHL_OFS  = 0;
    localparam int IP_PROTO_OFS = 4;
    localparam int UDP_DPRT_OFS = 11;
    localparam int PTP_IN_IP    = 14;
    localparam int SPID_OFS     = 10;
    localparam int SEQ_OFS      = 15;
    localparam int CLASS_OFS    = 24;

    typedef enum logic [1:0] {
        ENC_NONE = 2'd0,
        ENC_RAW  = 2'd1,
        ENC_IP   = 2'd2
    } encap_e;

    typedef struct packed {
        logic [SPID_W-1:0]  src_port;
        logic [SEQ_W-1:0]   seq_id;
        logic [CLASS_W-1:0] clock_class;
    } ann_fields_t;

    function automatic int payload_base(input logic vlan);
        return ETYPE_IDX + 1 + (vlan ? VLAN_SHIFT : 0);
    endfunction

    function automatic int ptp_base(input logic vlan, input encap_e enc);
        return payload_base(vlan) + ((enc == ENC_IP) ? PTP_IN_IP : 0);
    endfunction

endpackage

// File: rtl/ann_word_idx.sv
module ann_word_idx #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             fire,
    output logic [CNT_W-1:0] idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    assign fire = in_valid && (in_sof || active_q);
    assign idx  = in_sof ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (fire) begin
            active_q <= !in_eof;
            cnt_q    <= (idx == CNT_MAX) ? idx : idx + 1'b1;
        end
    end
endmodule

// File: rtl/ann_encap_cls.sv
module ann_encap_cls
    import ann_snoop_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              in_sof,
    input  logic [CNT_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    output logic              vlan,
    output encap_e            encap,
    output logic              hdr_ok
);
    int wi;
    int pb;

    always_comb begin
        wi = int'(idx);
        pb = payload_base(vlan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vlan   <= 1'b0;
            encap  <= ENC_NONE;
            hdr_ok <= 1'b0;
        end else if (fire) begin
            if (in_sof) begin
                vlan   <= 1'b0;
                encap  <= ENC_NONE;
                hdr_ok <= 1'b1;
            end else begin
                if (wi == ETYPE_IDX) begin
                    if (data == TYPE_VLAN)      vlan   <= 1'b1;
                    else if (data == TYPE_PTP)  encap  <= ENC_RAW;
                    else if (data == TYPE_IPV4) encap  <= ENC_IP;
                    else                        hdr_ok <= 1'b0;
                end else if (vlan && wi == ETYPE_IDX + VLAN_SHIFT) begin
                    if (data == TYPE_PTP)       encap  <= ENC_RAW;
                    else if (data == TYPE_IPV4) encap  <= ENC_IP;
                    else                        hdr_ok <= 1'b0;
                end
                if (encap == ENC_IP) begin
                    if (wi == pb + IP_VIHL_OFS && data[15:8] != IP_VIHL)
                        hdr_ok <= 1'b0;
                    if (wi == pb + IP_PROTO_OFS && data[7:0] != IP_UDP)
                        hdr_ok <= 1'b0;
                    if (wi == pb + UDP_DPRT_OFS && data != UDP_PORT)
                        hdr_ok <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/ann_field_ext.sv
module ann_field_ext
    import ann_snoop_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              in_sof,
    input  logic [CNT_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    input  logic              vlan,
    input  encap_e            encap,
    output logic              type_ok,
    output logic              got_class,
    output ann_fields_t       fields
);
    int rel;

    always_comb begin
        rel = int'(idx) - ptp_base(vlan, encap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            type_ok   <= 1'b0;
            got_class <= 1'b0;
            fields    <= '0;
        end else if (fire) begin
            if (in_sof) begin
                type_ok   <= 1'b0;
                got_class <= 1'b0;
            end else if (encap != ENC_NONE) begin
                if (rel == 0)
                    type_ok <= (data[11:8] == MSG_ANN);
                for (int k = 0; k < SPID_WORDS; k++) begin
                    if (rel == SPID_OFS + k)
                        fields.src_port[SPID_W-1-WORD_W*k -: WORD_W] <= data;
                end
                if (rel == SEQ_OFS)
                    fields.seq_id <= data;
                if (rel == CLASS_OFS) begin
                    fields.clock_class <= data[15:8];
                    got_class          <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ann_snoop.sv
module ann_snoop
    import ann_snoop_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [WORD_W-1:0]  in_data,
    output logic               out_done,
    output logic               out_announce,
    output logic [SEQ_W-1:0]   out_seq_id,
    output logic [SPID_W-1:0]  out_src_port,
    output logic [CLASS_W-1:0] out_clock_class
);
    logic             fire;
    logic [CNT_W-1:0] idx;
    logic             vlan;
    encap_e           encap;
    logic             hdr_ok;
    logic             type_ok;
    logic             got_class;
    ann_fields_t      fields;
    logic             done_q;

    ann_word_idx #(.CNT_W(CNT_W)) u_idx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .fire(fire), .idx(idx)
    );

    ann_encap_cls #(.CNT_W(CNT_W)) u_cls (
        .clk(clk), .rst(rst), .fire(fire), .in_sof(in_sof), .idx(idx),
        .data(in_data), .vlan(vlan), .encap(encap), .hdr_ok(hdr_ok)
    );

    ann_field_ext #(.CNT_W(CNT_W)) u_ext (
        .clk(clk), .rst(rst), .fire(fire), .in_sof(in_sof), .idx(idx),
        .data(in_data), .vlan(vlan), .encap(encap), .type_ok(type_ok),
        .got_class(got_class), .fields(fields)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= fire && in_eof;
    end

    assign out_done        = done_q;
    assign out_announce    = done_q && hdr_ok && type_ok && got_class;
    assign out_seq_id      = fields.seq_id;
    assign out_src_port    = fields.src_port;
    assign out_clock_class = fields.clock_class;
endmodule

// File: rtl/ann_snoop_chk.sv
module ann_snoop_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_sof,
    input logic        in_eof,
    input logic        out_done,
    input logic        out_announce,
    input logic [15:0] out_seq_id,
    input logic [79:0] out_src_port,
    input logic [7:0]  out_clock_class
);
    // R6: the strobe only follows an accepted last word
    p_done_after_eof_r6: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(in_valid && in_eof));

    // R6: detection is only reported together with the strobe
    p_announce_qualified_r6: assert property (@(posedge clk) disable iff (rst)
        out_announce |-> out_done);

    // R8: a one-word frame can never be an Announce
    p_single_word_r8: assert property (@(posedge clk) disable iff (rst)
        (out_done && $past(in_valid && in_sof && in_eof)) |-> !out_announce);

    // R10: idle cycles leave the captured fields untouched
    p_fields_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(out_seq_id) && $stable(out_src_port)
                              && $stable(out_clock_class)));
endmodule

bind ann_snoop ann_snoop_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .out_done(out_done), .out_announce(out_announce),
    .out_seq_id(out_seq_id), .out_src_port(out_src_port),
    .out_clock_class(out_clock_class)
);

// File: tb/ann_snoop_tb_top.sv
module ann_snoop_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_done;
    logic        out_announce;
    logic [15:0] out_seq_id;
    logic [79:0] out_src_port;
    logic [7:0]  out_clock_class;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [15:0] fr [0:79];
    int          fr_len;
    int          fr_ptp;
    int          fr_base;

    always #5 clk = ~clk;

    ann_snoop dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .out_done(out_done),
        .out_announce(out_announce), .out_seq_id(out_seq_id),
        .out_src_port(out_src_port), .out_clock_class(out_clock_class)
    );

    task automatic chk(input string req, input string what,
                       input logic [79:0] got, input logic [79:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic build(input int v, input int ip, input logic [15:0] seq,
                         input logic [7:0] cls, input logic [79:0] spid);
        fr_base = 7 + 2 * v;
        fr_ptp  = fr_base + (ip != 0 ? 14 : 0);
        fr_len  = fr_ptp + 25;
        for (int i = 0; i < 80; i++) fr[i] = 16'h1000 + 16'(i);
        if (v != 0) begin
            fr[6] = 16'h8100;
            fr[7] = 16'h0123;
        end
        fr[6 + 2 * v] = (ip != 0) ? 16'h0800 : 16'h88F7;
        if (ip != 0) begin
            fr[fr_base]      = 16'h4500;
            fr[fr_base + 4]  = 16'h4011;
            fr[fr_base + 11] = 16'd320;
        end
        fr[fr_ptp] = 16'h0B02;
        for (int k = 0; k < 5; k++) fr[fr_ptp + 10 + k] = spid[79 - 16 * k -: 16];
        fr[fr_ptp + 15] = seq;
        fr[fr_ptp + 24] = {cls, 8'h5A};
    endtask

    task automatic send(input int n, input int gap, input bit do_eof, input bit nowait);
        for (int i = 0; i < n; i++) begin
            if (!(nowait && i == 0)) @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = do_eof && (i == n - 1);
            in_data  = fr[i];
            if (gap > 0 && i != n - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_eof   = 1'b0;
                in_data  = 16'hDEAD;
                repeat (gap - 1) @(negedge clk);
            end
        end
    endtask

    task automatic check_now(input string req, input bit exp_ann, input logic [15:0] seq,
                             input logic [7:0] cls, input logic [79:0] spid);
        chk(req, "done", 80'(out_done), 80'(1'b1));
        chk(req, "announce", 80'(out_announce), 80'(exp_ann));
        if (exp_ann) begin
            chk(req, "seq_id", 80'(out_seq_id), 80'(seq));
            chk(req, "clock_class", 80'(out_clock_class), 80'(cls));
            chk(req, "src_port", out_src_port, spid);
        end
    endtask

    task automatic expect_res(input string req, input bit exp_ann, input logic [15:0] seq,
                              input logic [7:0] cls, input logic [79:0] spid);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        check_now(req, exp_ann, seq, cls, spid);
        @(negedge clk);
        chk("R6", "done one cycle", 80'(out_done), 80'(1'b0));
    endtask

    localparam logic [79:0] SP_A = 80'h0011_2233_4455_6677_8899;
    localparam logic [79:0] SP_B = 80'hA1B2_C3D4_E5F6_0718_293A;

    task automatic t_reset();
        chk("R1", "done", 80'(out_done), 80'(1'b0));
        chk("R1", "announce", 80'(out_announce), 80'(1'b0));
        chk("R1", "seq_id", 80'(out_seq_id), 80'(0));
        chk("R1", "clock_class", 80'(out_clock_class), 80'(0));
        chk("R1", "src_port", out_src_port, 80'(0));
    endtask

    task automatic t_raw();
        build(0, 0, 16'h1234, 8'd6, SP_A);
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R2", 1'b1, 16'h1234, 8'd6, SP_A);
        build(0, 0, 16'h4321, 8'd7, SP_B);
        fr[fr_ptp] = 16'hFB02;
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R7", 1'b1, 16'h4321, 8'd7, SP_B);
    endtask

    task automatic t_vlan();
        build(1, 0, 16'hBEEF, 8'd248, SP_B);
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R3", 1'b1, 16'hBEEF, 8'd248, SP_B);
        build(1, 1, 16'h0F0F, 8'd52, SP_A);
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R3", 1'b1, 16'h0F0F, 8'd52, SP_A);
    endtask

    task automatic t_ip();
        build(0, 1, 16'h7777, 8'd135, SP_A);
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R4", 1'b1, 16'h7777, 8'd135, SP_A);
    endtask

    task automatic t_ip_bad();
        build(0, 1, 16'h1, 8'd1, SP_A);
        fr[fr_base] = 16'h4600;
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R5", 1'b0, 16'h0, 8'h0, 80'h0);
        build(0, 1, 16'h1, 8'd1, SP_A);
        fr[fr_base + 4] = 16'h4006;
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R5", 1'b0, 16'h0, 8'h0, 80'h0);
        build(1, 1, 16'h1, 8'd1, SP_A);
        fr[fr_base + 11] = 16'd319;
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R5", 1'b0, 16'h0, 8'h0, 80'h0);
    endtask

    task automatic t_reject();
        build(0, 0, 16'h2, 8'd2, SP_B);
        fr[fr_ptp] = 16'h0002;
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R7", 1'b0, 16'h0, 8'h0, 80'h0);
        build(0, 0, 16'h2, 8'd2, SP_B);
        fr[6] = 16'h86DD;
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R7", 1'b0, 16'h0, 8'h0, 80'h0);
        build(1, 0, 16'h2, 8'd2, SP_B);
        fr[8] = 16'h8100;
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R7", 1'b0, 16'h0, 8'h0, 80'h0);
    endtask

    task automatic t_short();
        build(0, 0, 16'h3, 8'd3, SP_A);
        send(fr_len - 1, 0, 1'b1, 1'b0);
        expect_res("R8", 1'b0, 16'h0, 8'h0, 80'h0);
        build(1, 1, 16'h3, 8'd3, SP_A);
        send(fr_len - 1, 0, 1'b1, 1'b0);
        expect_res("R8", 1'b0, 16'h0, 8'h0, 80'h0);
        build(0, 0, 16'h3, 8'd3, SP_A);
        send(1, 0, 1'b1, 1'b0);
        expect_res("R8", 1'b0, 16'h0, 8'h0, 80'h0);
    endtask

    task automatic t_restart();
        build(0, 0, 16'hAAAA, 8'd10, SP_A);
        send(fr_len, 0, 1'b1, 1'b0);
        @(negedge clk);
        check_now("R9", 1'b1, 16'hAAAA, 8'd10, SP_A);
        build(0, 1, 16'hBBBB, 8'd20, SP_B);
        fr[fr_base + 4] = 16'h4006;
        send(fr_len, 0, 1'b1, 1'b1);
        expect_res("R9", 1'b0, 16'h0, 8'h0, 80'h0);
        build(0, 0, 16'hCCCC, 8'd30, SP_A);
        send(12, 0, 1'b0, 1'b0);
        build(1, 1, 16'hDDDD, 8'd40, SP_B);
        send(fr_len, 0, 1'b1, 1'b0);
        expect_res("R9", 1'b1, 16'hDDDD, 8'd40, SP_B);
    endtask

    task automatic t_gaps();
        build(0, 1, 16'h5151, 8'd187, SP_A);
        send(fr_len, 2, 1'b1, 1'b0);
        expect_res("R10", 1'b1, 16'h5151, 8'd187, SP_A);
        repeat (3) @(negedge clk);
        chk("R10", "seq hold", 80'(out_seq_id), 80'(16'h5151));
        chk("R10", "done idle", 80'(out_done), 80'(1'b0));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raw();
        t_vlan();
        t_ip();
        t_ip_bad();
        t_reject();
        t_short();
        t_restart();
        t_gaps();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule